// File: doc/BRIEF.md
# Processor Bus Cycle Interface

This block connects a small 8-bit processor core to external memory and peripherals. The core asks for a bus cycle by pulsing a request together with a cycle code, a 14-bit address and, for writes, a data byte. The block latches the address, which reaches 16K bytes, and holds it for the whole cycle. It raises a strobe that names the cycle as an instruction fetch, a memory read or a memory write. It drives the shared 8-bit output bus and, at the end of the cycle, returns a byte taken either from the memory input bus or from the peripheral input bus.

For I/O cycles the five upper address bits give a peripheral number from 0 to 31. Numbers 0 to 7 are input devices, and each of them has a select line. Numbers 8 to 31 are output devices, and each of them has a one-clock write strobe. A cycle lasts a fixed number of clock periods. During memory cycles, a wait input from a slow memory is sampled at one fixed phase, and each clock in which it is seen high adds one period to the cycle.

Top module: `bus_cycle_if`

## Requirements
- R1: After reset the cycle strobes, device selects, device strobes, `cpu_done`, `bus_addr`, `bus_dout` and `cpu_rdata` are all zero.
- R2: `bus_addr` takes the value of `cpu_addr` when a request is accepted and holds it until the next accepted request, even if `cpu_addr` changes.
- R3: Cycle codes are 0 = fetch, 1 = memory read, 2 = memory write, 3 = I/O input, 4 = I/O output. `fetch`, `mem_rd` and `mem_wr` are each high on every clock of a cycle of their own code, and at no other time.
- R4: Without wait states a cycle lasts CYCLE_LEN (default 10) clocks, counted from the clock after the request is accepted. `cpu_done` is high for exactly one clock, the first clock after the cycle ends.
- R5: In a memory cycle (codes 0 to 2), each clock edge at phase WAIT_PHASE (default 3) that sees `mem_wait` high adds one clock to the cycle. The address, the strobes and the output data stay unchanged while the cycle is held.
- R6: `mem_wait` has no effect on I/O cycles (codes 3 and 4), which always last CYCLE_LEN clocks.
- R7: An I/O output cycle whose peripheral number `cpu_addr[13:9]` is 8 to 31 pulses `io_out_stb[n-8]` for exactly one clock, at phase WAIT_PHASE+1, which is the fifth clock of the cycle. No memory strobe is high during an I/O cycle, and no device line is high during a memory cycle.
- R8: An I/O input cycle whose peripheral number n is 0 to 7 holds `io_in_sel[n]` high for the whole cycle. `cpu_rdata` then receives `io_din` rather than `mem_din`.
- R9: An I/O input cycle with a number of 8 or more raises no input select. An I/O output cycle with a number below 8 raises no output strobe.
- R10: `bus_dout` carries the request's write byte for the whole of a memory write or I/O output cycle, and is zero otherwise.
- R11: A fetch or memory read cycle loads `mem_din` into `cpu_rdata` on its final clock. Write cycles leave `cpu_rdata` unchanged.
- R12: A request that arrives while a cycle is running, or that carries a code from 5 to 7, is ignored and starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_req | input | 1 | Cycle request from the core, one clock |
| cpu_cyc | input | 3 | Cycle code that goes with the request |
| cpu_addr | input | 14 | Address, or peripheral number in bits 13..9 |
| cpu_wdata | input | 8 | Write byte for memory write or I/O output |
| cpu_rdata | output | 8 | Byte returned by the last read-type cycle |
| cpu_done | output | 1 | One-clock pulse at the end of a cycle |
| mem_wait | input | 1 | Wait request from slow memory |
| mem_din | input | 8 | Memory input bus |
| io_din | input | 8 | Peripheral input bus |
| bus_addr | output | 14 | Latched address bus |
| bus_dout | output | 8 | Output bus shared by memory and output devices |
| fetch | output | 1 | Instruction fetch cycle in progress |
| mem_rd | output | 1 | Memory read cycle in progress |
| mem_wr | output | 1 | Memory write cycle in progress |
| io_in_sel | output | 8 | One-hot select of input device 0..7 |
| io_out_stb | output | 24 | One-hot write strobe of output device 8..31 |

## Verification
Each of the five cycle codes is run, and the number of clocks for which each strobe is seen is recorded. This tells a wrong strobe apart from a wrong cycle length. Memory cycles are run with zero, one and three wait clocks, and I/O cycles with the wait line held high, which separates correct wait counting from wait handling that leaks into I/O cycles. Output devices 8, 20 and 31 and input devices 0, 5 and 7 are tried with different bytes on the two input buses, so that an off-by-one decode or a swapped read path shows up. Requests with mismatched device ranges, an unused code, and a request made in the middle of a cycle check that nothing extra starts.

// File: rtl/bci_pkg.sv
package bci_pkg;

  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_MRD   = 3'd1,
    CYC_MWR   = 3'd2,
    CYC_IOIN  = 3'd3,
    CYC_IOOUT = 3'd4
  } cyc_e;

  localparam logic [2:0] CYC_MAX_CODE = 3'd4;

  function automatic logic cyc_is_mem(cyc_e c);
    return (c == CYC_FETCH) || (c == CYC_MRD) || (c == CYC_MWR);
  endfunction

  function automatic logic cyc_drives_out(cyc_e c);
    return (c == CYC_MWR) || (c == CYC_IOOUT);
  endfunction

endpackage

// File: rtl/bci_sequencer.sv
module bci_sequencer #(
  parameter int CYCLE_LEN  = 10,
  parameter int WAIT_PHASE = 3,
  parameter int PH_W       = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            wait_ok,
  input  logic            mem_wait,
  output logic            active,
  output logic [PH_W-1:0] phase,
  output logic            last,
  output logic            done
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(CYCLE_LEN - 1);
  localparam logic [PH_W-1:0] WAIT_PH = PH_W'(WAIT_PHASE);

  logic            active_q, active_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            done_q;
  logic            hold;

  always_comb begin
    hold     = active_q & wait_ok & mem_wait & (phase_q == WAIT_PH);
    last     = active_q & ~hold & (phase_q == LAST_PH);
    active_d = active_q;
    phase_d  = phase_q;
    if (!active_q) begin
      if (start) begin
        active_d = 1'b1;
        phase_d  = '0;
      end
    end else if (last) begin
      active_d = 1'b0;
      phase_d  = '0;
    end else if (!hold) begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      done_q   <= last;
    end
  end

  assign active = active_q;
  assign phase  = phase_q;
  assign done   = done_q;

endmodule

// File: rtl/bci_latch.sv
module bci_latch
  import bci_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [2:0]        cyc_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_din,
  input  logic [DATA_W-1:0] io_din,
  output cyc_e              cyc_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  cyc_e              cyc_r;
  logic [ADDR_W-1:0] addr_r;
  logic [DATA_W-1:0] wdata_r, rdata_r, rdata_d;
  logic              rdata_en;

  always_comb begin
    rdata_en = 1'b0;
    rdata_d  = mem_din;
    if (capture) begin
      case (cyc_r)
        CYC_FETCH, CYC_MRD: begin
          rdata_en = 1'b1;
          rdata_d  = mem_din;
        end
        CYC_IOIN: begin
          rdata_en = 1'b1;
          rdata_d  = io_din;
        end
        default: rdata_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_r   <= CYC_FETCH;
      addr_r  <= '0;
      wdata_r <= '0;
    end else if (load) begin
      cyc_r   <= cyc_e'(cyc_in);
      addr_r  <= addr_in;
      wdata_r <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_r <= '0;
    end else if (rdata_en) begin
      rdata_r <= rdata_d;
    end
  end

  assign cyc_q   = cyc_r;
  assign addr_q  = addr_r;
  assign wdata_q = wdata_r;
  assign rdata_q = rdata_r;

endmodule

// File: rtl/bci_io_decode.sv
module bci_io_decode
  import bci_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int DEV_W      = 5,
  parameter int IN_DEVS    = 8,
  parameter int OUT_DEVS   = (1 << DEV_W) - IN_DEVS,
  parameter int STB_PHASE  = 4,
  parameter int PH_W       = 4
) (
  input  logic                active,
  input  cyc_e                cyc,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [PH_W-1:0]     phase,
  output logic                fetch,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [DATA_W-1:0]   dout,
  output logic [IN_DEVS-1:0]  io_in_sel,
  output logic [OUT_DEVS-1:0] io_out_stb
);

  localparam logic [PH_W-1:0] STB_PH = PH_W'(STB_PHASE);

  logic [DEV_W-1:0] dev;
  logic             in_cyc, out_cyc, out_slot;

  assign dev      = addr[ADDR_W-1 -: DEV_W];
  assign in_cyc   = active & (cyc == CYC_IOIN);
  assign out_cyc  = active & (cyc == CYC_IOOUT);
  assign out_slot = out_cyc & (phase == STB_PH);

  assign fetch  = active & (cyc == CYC_FETCH);
  assign mem_rd = active & (cyc == CYC_MRD);
  assign mem_wr = active & (cyc == CYC_MWR);
  assign dout   = (active & cyc_drives_out(cyc)) ? wdata : '0;

  for (genvar gi = 0; gi < IN_DEVS; gi++) begin : g_in
    assign io_in_sel[gi] = in_cyc & (dev == DEV_W'(gi));
  end

  for (genvar go = 0; go < OUT_DEVS; go++) begin : g_out
    assign io_out_stb[go] = out_slot & (dev == DEV_W'(go + IN_DEVS));
  end

endmodule

// File: rtl/bus_cycle_if.sv
module bus_cycle_if
  import bci_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int DEV_W      = 5,
  parameter int IN_DEVS    = 8,
  parameter int CYCLE_LEN  = 10,
  parameter int WAIT_PHASE = 3,
  parameter int OUT_DEVS   = (1 << DEV_W) - IN_DEVS,
  parameter int PH_W       = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic [2:0]          cpu_cyc,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_done,
  input  logic                mem_wait,
  input  logic [DATA_W-1:0]   mem_din,
  input  logic [DATA_W-1:0]   io_din,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_dout,
  output logic                fetch,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [IN_DEVS-1:0]  io_in_sel,
  output logic [OUT_DEVS-1:0] io_out_stb
);

  logic              rst_s1, rst_s2;
  logic              act, last, start, wait_ok;
  logic [PH_W-1:0]   phase;
  cyc_e              cyc_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  assign start   = cpu_req & ~act & (cpu_cyc <= CYC_MAX_CODE);
  assign wait_ok = cyc_is_mem(cyc_q);

  bci_sequencer #(
    .CYCLE_LEN (CYCLE_LEN),
    .WAIT_PHASE(WAIT_PHASE),
    .PH_W      (PH_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_s2),
    .start   (start),
    .wait_ok (wait_ok),
    .mem_wait(mem_wait),
    .active  (act),
    .phase   (phase),
    .last    (last),
    .done    (cpu_done)
  );

  bci_latch #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_latch (
    .clk     (clk),
    .rst_n   (rst_s2),
    .load    (start),
    .cyc_in  (cpu_cyc),
    .addr_in (cpu_addr),
    .wdata_in(cpu_wdata),
    .capture (last),
    .mem_din (mem_din),
    .io_din  (io_din),
    .cyc_q   (cyc_q),
    .addr_q  (bus_addr),
    .wdata_q (wdata_q),
    .rdata_q (cpu_rdata)
  );

  bci_io_decode #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DEV_W    (DEV_W),
    .IN_DEVS  (IN_DEVS),
    .OUT_DEVS (OUT_DEVS),
    .STB_PHASE(WAIT_PHASE + 1),
    .PH_W     (PH_W)
  ) u_dec (
    .active    (act),
    .cyc       (cyc_q),
    .addr      (bus_addr),
    .wdata     (wdata_q),
    .phase     (phase),
    .fetch     (fetch),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .dout      (bus_dout),
    .io_in_sel (io_in_sel),
    .io_out_stb(io_out_stb)
  );

endmodule

// File: rtl/bci_checker.sv
module bci_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        active,
  input logic        cpu_done,
  input logic        fetch,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [13:0] bus_addr,
  input logic [7:0]  bus_dout,
  input logic [7:0]  io_in_sel,
  input logic [23:0] io_out_stb
);

  assert_type_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch, mem_rd, mem_wr}));

  assert_type_in_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch | mem_rd | mem_wr) |-> active);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(bus_addr));

  assert_dout_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(bus_dout));

  assert_done_after_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> cpu_done);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  assert_out_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(io_out_stb));

  assert_out_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_out_stb != '0) |=> (io_out_stb == '0));

  assert_io_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_out_stb != '0) || (io_in_sel != '0)) |-> !(fetch | mem_rd | mem_wr));

  assert_in_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(io_in_sel));

  assert_in_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(io_in_sel));

endmodule

bind bus_cycle_if bci_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .active    (act),
  .cpu_done  (cpu_done),
  .fetch     (fetch),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .bus_addr  (bus_addr),
  .bus_dout  (bus_dout),
  .io_in_sel (io_in_sel),
  .io_out_stb(io_out_stb)
);

// File: tb/tb_bus_cycle_if.sv
module tb_bus_cycle_if;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [2:0]  cpu_cyc = 3'd0;
  logic [13:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        mem_wait = 1'b0;
  logic [7:0]  mem_din = 8'hA5;
  logic [7:0]  io_din = 8'h3C;
  logic [7:0]  cpu_rdata;
  logic        cpu_done;
  logic [13:0] bus_addr;
  logic [7:0]  bus_dout;
  logic        fetch, mem_rd, mem_wr;
  logic [7:0]  io_in_sel;
  logic [23:0] io_out_stb;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  // results of the last run_cycle
  int          len, n_fetch, n_rd, n_wr, n_ostb, ostb_j;
  logic [23:0] ostb_val;
  logic [7:0]  in_or, in_and;
  bit          addr_bad, dout_bad, done_twice;
  logic [7:0]  rd_at_done;

  always #10 clk = ~clk;

  bus_cycle_if dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_cyc(cpu_cyc),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_done(cpu_done), .mem_wait(mem_wait), .mem_din(mem_din),
    .io_din(io_din), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .fetch(fetch), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_in_sel(io_in_sel), .io_out_stb(io_out_stb)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic run_cycle(input logic [2:0] c, input logic [13:0] a, input logic [7:0] wd, input int waits);
    logic [7:0] exp_dout;
    int j;
    exp_dout = (c == 3'd2 || c == 3'd4) ? wd : 8'h00;
    @(negedge clk);
    cpu_req = 1'b1; cpu_cyc = c; cpu_addr = a; cpu_wdata = wd;
    mem_wait = (waits > 0);
    @(negedge clk);
    cpu_req = 1'b0; cpu_addr = ~a; cpu_wdata = ~wd;
    len = 0; n_fetch = 0; n_rd = 0; n_wr = 0; n_ostb = 0; ostb_j = -1;
    ostb_val = '0; in_or = '0; in_and = '1; addr_bad = 0; dout_bad = 0;
    j = 0;
    while (!cpu_done && j < 100) begin
      if (j == 3 + waits) mem_wait = 1'b0;
      if (bus_addr != a) addr_bad = 1;
      if (bus_dout != exp_dout) dout_bad = 1;
      n_fetch += int'(fetch); n_rd += int'(mem_rd); n_wr += int'(mem_wr);
      if (io_out_stb != '0) begin n_ostb++; ostb_val = io_out_stb; ostb_j = j; end
      in_or  = in_or | io_in_sel;
      in_and = in_and & io_in_sel;
      j++;
      @(negedge clk);
    end
    mem_wait = 1'b0;
    len = j;
    rd_at_done = cpu_rdata;
    @(negedge clk);
    done_twice = cpu_done;
  endtask

  task automatic t_reset();
    chk(fetch == 0 && mem_rd == 0 && mem_wr == 0, "R1 type strobes", {fetch, mem_rd, mem_wr}, 0);
    chk(io_in_sel == 0 && io_out_stb == 0, "R1 device lines", {io_in_sel, io_out_stb}, 0);
    chk(cpu_done == 0 && bus_addr == 0, "R1 done/addr", {cpu_done, bus_addr}, 0);
    chk(bus_dout == 0 && cpu_rdata == 0, "R1 data", {bus_dout, cpu_rdata}, 0);
  endtask

  task automatic t_fetch();
    mem_din = 8'h5A;
    run_cycle(3'd0, 14'h1234, 8'h11, 0);
    chk(len == 10, "R4 fetch length", len, 10);
    chk(n_fetch == 10 && n_rd == 0 && n_wr == 0, "R3 fetch strobe", {n_fetch, n_rd, n_wr}, 10);
    chk(!addr_bad, "R2 address held", addr_bad, 0);
    chk(!dout_bad, "R10 dout zero on fetch", dout_bad, 0);
    chk(rd_at_done == 8'h5A, "R11 fetch data", rd_at_done, 8'h5A);
    chk(!done_twice, "R4 done single pulse", done_twice, 0);
    chk(in_or == 0 && n_ostb == 0, "R7 no device line in memory cycle", in_or, 0);
  endtask

  task automatic t_read_wait();
    mem_din = 8'hC3;
    run_cycle(3'd1, 14'h3FFF, 8'h00, 3);
    chk(len == 13, "R5 three wait clocks", len, 13);
    chk(n_rd == 13 && n_fetch == 0 && n_wr == 0, "R3 read strobe", n_rd, 13);
    chk(!addr_bad, "R5 address held in wait", addr_bad, 0);
    chk(rd_at_done == 8'hC3, "R11 read data", rd_at_done, 8'hC3);
  endtask

  task automatic t_write_wait();
    mem_din = 8'h77;
    run_cycle(3'd2, 14'h0001, 8'h96, 1);
    chk(len == 11, "R5 one wait clock", len, 11);
    chk(n_wr == 11 && n_rd == 0, "R3 write strobe", n_wr, 11);
    chk(!dout_bad, "R10 write data on bus", dout_bad, 0);
    chk(rd_at_done == 8'hC3, "R11 write leaves rdata", rd_at_done, 8'hC3);
  endtask

  task automatic t_io_out(input int dev, input logic [7:0] wd);
    run_cycle(3'd4, {dev[4:0], 9'h0AB}, wd, 2);
    chk(len == 10, "R6 wait ignored on output", len, 10);
    chk(n_ostb == 1, "R7 strobe count", n_ostb, 1);
    chk(ostb_val == (24'd1 << (dev - 8)), "R7 strobe index", ostb_val, 24'd1 << (dev - 8));
    chk(ostb_j == 4, "R7 strobe phase", ostb_j, 4);
    chk(n_fetch + n_rd + n_wr == 0, "R7 no memory strobe in I/O", n_fetch + n_rd + n_wr, 0);
    chk(!dout_bad, "R10 output data on bus", dout_bad, 0);
  endtask

  task automatic t_io_in(input int dev, input logic [7:0] d);
    io_din = d; mem_din = ~d;
    run_cycle(3'd3, {dev[4:0], 9'h155}, 8'hEE, 2);
    chk(len == 10, "R6 wait ignored on input", len, 10);
    chk(in_and == (8'd1 << dev) && in_or == (8'd1 << dev), "R8 input select", {in_and, in_or}, {8'd1 << dev, 8'd1 << dev});
    chk(rd_at_done == d, "R8 input data routed", rd_at_done, d);
    chk(n_fetch + n_rd + n_wr == 0 && n_ostb == 0, "R7 no other strobe in input", n_ostb, 0);
  endtask

  task automatic t_mismatch();
    run_cycle(3'd3, {5'd12, 9'h0}, 8'h00, 0);
    chk(in_or == 0 && n_ostb == 0, "R9 input cycle to output device", in_or, 0);
    run_cycle(3'd4, {5'd3, 9'h0}, 8'h42, 0);
    chk(n_ostb == 0 && in_or == 0, "R9 output cycle to input device", n_ostb, 0);
  endtask

  task automatic t_ignored();
    int seen;
    @(negedge clk);
    cpu_req = 1'b1; cpu_cyc = 3'd6; cpu_addr = 14'h2222;
    @(negedge clk);
    cpu_req = 1'b0;
    seen = 0;
    for (int k = 0; k < 15; k++) begin
      seen += int'(fetch | mem_rd | mem_wr | cpu_done | (io_in_sel != 0) | (io_out_stb != 0));
      @(negedge clk);
    end
    chk(seen == 0 && bus_addr != 14'h2222, "R12 unused code ignored", seen, 0);
    // request in the middle of a running fetch
    @(negedge clk);
    cpu_req = 1'b1; cpu_cyc = 3'd0; cpu_addr = 14'h0400;
    @(negedge clk);
    cpu_req = 1'b0;
    repeat (4) @(negedge clk);
    cpu_req = 1'b1; cpu_cyc = 3'd2; cpu_addr = 14'h0999; cpu_wdata = 8'h55;
    @(negedge clk);
    cpu_req = 1'b0;
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      seen += int'(mem_wr);
      @(negedge clk);
    end
    chk(seen == 0 && bus_addr == 14'h0400, "R12 request while busy ignored", {seen, bus_addr}, 14'h0400);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fetch();
    t_read_wait();
    t_write_wait();
    t_io_out(20, 8'h81);
    t_io_out(8, 8'h01);
    t_io_out(31, 8'hFE);
    t_io_in(5, 8'h3C);
    t_io_in(0, 8'h9D);
    t_io_in(7, 8'h60);
    t_mismatch();
    t_ignored();
    report();
  end

endmodule